// File: doc/BRIEF.md
# Status and Interrupt Enable Controller

This block gathers condition signals from a data-acquisition front end and sorts them into two status groups. The operation group covers progress: measuring, scan done, front-end trigger, buffer half full, measurement done and the algorithm's software request. The questionable group covers faults: early trigger, buffer overrun and input overvoltage. Each group keeps three registers. The condition register shows the present state. The event register latches the rising edges of the conditions and clears when the host reads it. The enable mask selects which latched events count.

One mask bit does two jobs. It admits its event into the group summary bit, and it lets that event drive the single level-sensitive interrupt request. A cause vector shows which enabled events are pending. A preset strobe clears both masks, so no interrupt can be raised. An operation-complete arm strobe temporarily enables the measurement-done interrupt; the arm drops once the host has read the event that it let through. An overvoltage latches the input-open indication until a full reset.

Top module: `stat_irq_ctrl`

## Requirements
- R1: Each condition bit latches its event bit on a 0-to-1 transition. The event bit holds until it is read or reset. Operation bits: 0 measuring, 1 scan done, 2 front-end trigger, 3 half full, 4 measurement done, 5 algorithm request. Questionable bits: 0 early trigger, 1 overrun, 2 overvoltage.
- R2: `operSum`/`quesSum` are the OR of the group's event bits ANDed with its mask. `irqCause` is {questionable pending[2:0], operation pending[5:0]}. `irqReq` is high while any cause bit is set.
- R3: Register map on `regAddr`: 0 operation condition, 1 operation event, 2 operation mask, 4 questionable condition, 5 questionable event, 6 questionable mask; other addresses read 0. Read data appears on `regRdata` one cycle after `regRd`. Reading an event register returns its value and clears it. An event set in the same cycle as the read survives.
- R4: Early trigger is flagged only when `trigIn` is high while `trigReady` is low.
- R5: Overrun is flagged only when `fifoWr` is high while `fifoFull` is high.
- R6: The half-full condition is `fifoCount >= 32768`. Staying above the mark latches one event; a new event needs a fall below the mark and a new crossing.
- R7: `measStart` sets the measuring condition (bit 0). `measDone` clears it and raises the measurement-done condition (bit 4).
- R8: `presetIn` clears both masks and the operation-complete arm. Latched events are left as they are.
- R9: `opcArm` enables the measurement-done interrupt (cause bit 4) without changing `operSum`. `opcPosted` pulses for one cycle after a measurement-done event latches while armed. The arm clears when the operation event register is read with bit 4 set. A bit 4 enable in the mask stays in force.
- R10: An `overVolt` pulse sets `inputOpen` and questionable condition bit 2. Both stay set through reads and preset until `rstN` is low.
- R11: After reset, all registers, masks, the arm, `irqReq`, the summary bits and `inputOpen` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low full reset |
| regAddr | input | 3 | Register select |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe (mask registers) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, one cycle after regRd |
| presetIn | input | 1 | Clear masks and arm |
| opcArm | input | 1 | Arm operation-complete interrupt |
| trigIn | input | 1 | Trigger arrival |
| trigReady | input | 1 | Trigger logic ready |
| fifoWr | input | 1 | Data word written to buffer |
| fifoFull | input | 1 | Buffer full |
| fifoCount | input | 17 | Buffer fill level |
| scanDone | input | 1 | Scan list finished pulse |
| scpTrig | input | 1 | Front-end trigger pulse |
| measStart | input | 1 | Measurement started pulse |
| measDone | input | 1 | Sequencer left wait-for-arm pulse |
| algIrq | input | 1 | Algorithm software request pulse |
| overVolt | input | 1 | Overvoltage detected pulse |
| operSum | output | 1 | Operation group summary |
| quesSum | output | 1 | Questionable group summary |
| irqReq | output | 1 | Level interrupt request |
| irqCause | output | 9 | Pending enabled causes |
| opcPosted | output | 1 | Operation-complete posted pulse |
| inputOpen | output | 1 | Sticky overvoltage indication |

## Verification
The hardest case to reach is the arm's self-clearing. It needs an arm, a full measuring cycle and a read of the operation event register with bit 4 pending. After that, a second measurement cycle must stay quiet or stay enabled, depending on the mask. The stimulus runs this sequence twice: once with the mask bit clear and once with it set. A read is also issued in the same cycle as a new event, to show that the set wins over the clear. The half-full mark is approached from one below, held above and re-crossed, to show that only one event latches per crossing.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int OPER_W  = 6;
  localparam int QUES_W  = 3;
  localparam int CAUSE_W = OPER_W + QUES_W;

  // operation group bit positions
  localparam int OB_MEAS = 0;
  localparam int OB_SCAN = 1;
  localparam int OB_SCP  = 2;
  localparam int OB_HALF = 3;
  localparam int OB_DONE = 4;
  localparam int OB_ALG  = 5;
  // questionable group bit positions
  localparam int QB_EARLY = 0;
  localparam int QB_OVR   = 1;
  localparam int QB_VOLT  = 2;

  localparam logic [2:0] ADDR_OPER_COND = 3'd0;
  localparam logic [2:0] ADDR_OPER_EVT  = 3'd1;
  localparam logic [2:0] ADDR_OPER_EN   = 3'd2;
  localparam logic [2:0] ADDR_QUES_COND = 3'd4;
  localparam logic [2:0] ADDR_QUES_EVT  = 3'd5;
  localparam logic [2:0] ADDR_QUES_EN   = 3'd6;

  typedef struct packed {
    logic clrOperEvt;
    logic clrQuesEvt;
    logic ldOperEn;
    logic ldQuesEn;
    logic clrMasks;
    logic armed;
  } ctlStrobeT;
endpackage

// File: rtl/stat_irq_ctl.sv
module stat_irq_ctl
  import stat_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regAddr,
  input  logic       regRd,
  input  logic       regWr,
  input  logic       presetIn,
  input  logic       opcArm,
  input  logic       doneEvtPending,
  input  logic       doneEvtSet,
  output ctlStrobeT  strobe,
  output logic       opcPosted
);
  logic armedQ;
  logic rdOperEvt;

  assign rdOperEvt = regRd && (regAddr == ADDR_OPER_EVT);

  // arm: set by opcArm, dropped by preset or by delivery of the event it enabled
  always_ff @(posedge clk) begin
    if (!rstN)                                armedQ <= 1'b0;
    else if (presetIn)                        armedQ <= 1'b0;
    else if (opcArm)                          armedQ <= 1'b1;
    else if (rdOperEvt && doneEvtPending)     armedQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) opcPosted <= 1'b0;
    else       opcPosted <= armedQ && doneEvtSet;
  end

  always_comb begin
    strobe.clrOperEvt = rdOperEvt;
    strobe.clrQuesEvt = regRd && (regAddr == ADDR_QUES_EVT);
    strobe.ldOperEn   = regWr && (regAddr == ADDR_OPER_EN) && !presetIn;
    strobe.ldQuesEn   = regWr && (regAddr == ADDR_QUES_EN) && !presetIn;
    strobe.clrMasks   = presetIn;
    strobe.armed      = armedQ;
  end
endmodule

// File: rtl/stat_irq_dp.sv
module stat_irq_dp
  import stat_irq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 17,
  parameter int HALF_MARK = 32768
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobeT          strobe,
  input  logic [2:0]         regAddr,
  input  logic               regRd,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic               trigIn,
  input  logic               trigReady,
  input  logic               fifoWr,
  input  logic               fifoFull,
  input  logic [CNT_W-1:0]   fifoCount,
  input  logic               scanDone,
  input  logic               scpTrig,
  input  logic               measStart,
  input  logic               measDone,
  input  logic               algIrq,
  input  logic               overVolt,
  output logic               operSum,
  output logic               quesSum,
  output logic               irqReq,
  output logic [CAUSE_W-1:0] irqCause,
  output logic               inputOpen,
  output logic               doneEvtPending,
  output logic               doneEvtSet,
  output logic [OPER_W-1:0]  operEvt,
  output logic [QUES_W-1:0]  quesEvt,
  output logic [DATA_W-1:0]  operEn,
  output logic [DATA_W-1:0]  quesEn
);
  localparam logic [CNT_W-1:0] MARK = CNT_W'(HALF_MARK);

  logic              measuring;
  logic              voltLatch;
  logic [OPER_W-1:0] operCond, operPrev, operSet, operGate;
  logic [QUES_W-1:0] quesCond, quesPrev, quesSet;

  always_ff @(posedge clk) begin
    if (!rstN)          measuring <= 1'b0;
    else if (measDone)  measuring <= 1'b0;
    else if (measStart) measuring <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         voltLatch <= 1'b0;
    else if (overVolt) voltLatch <= 1'b1;
  end
  assign inputOpen = voltLatch;

  always_comb begin
    operCond          = '0;
    operCond[OB_MEAS] = measuring;
    operCond[OB_SCAN] = scanDone;
    operCond[OB_SCP]  = scpTrig;
    operCond[OB_HALF] = (fifoCount >= MARK);
    operCond[OB_DONE] = measDone;
    operCond[OB_ALG]  = algIrq;
    quesCond           = '0;
    quesCond[QB_EARLY] = trigIn && !trigReady;
    quesCond[QB_OVR]   = fifoWr && fifoFull;
    quesCond[QB_VOLT]  = voltLatch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      operPrev <= '0;
      quesPrev <= '0;
    end else begin
      operPrev <= operCond;
      quesPrev <= quesCond;
    end
  end

  assign operSet = operCond & ~operPrev;
  assign quesSet = quesCond & ~quesPrev;

  // per-bit event latches: a new edge beats a read-clear in the same cycle
  for (genvar i = 0; i < OPER_W; i++) begin : gOperEvt
    always_ff @(posedge clk) begin
      if (!rstN) operEvt[i] <= 1'b0;
      else       operEvt[i] <= operSet[i] | (operEvt[i] & ~strobe.clrOperEvt);
    end
  end
  for (genvar i = 0; i < QUES_W; i++) begin : gQuesEvt
    always_ff @(posedge clk) begin
      if (!rstN) quesEvt[i] <= 1'b0;
      else       quesEvt[i] <= quesSet[i] | (quesEvt[i] & ~strobe.clrQuesEvt);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrMasks) begin
      operEn <= '0;
      quesEn <= '0;
    end else begin
      if (strobe.ldOperEn) operEn <= regWdata;
      if (strobe.ldQuesEn) quesEn <= regWdata;
    end
  end

  always_comb begin
    operGate          = operEn[OPER_W-1:0];
    operGate[OB_DONE] = operEn[OB_DONE] | strobe.armed;
  end

  assign operSum  = |(operEvt & operEn[OPER_W-1:0]);
  assign quesSum  = |(quesEvt & quesEn[QUES_W-1:0]);
  assign irqCause = {quesEvt & quesEn[QUES_W-1:0], operEvt & operGate};
  assign irqReq   = |irqCause;

  assign doneEvtPending = operEvt[OB_DONE];
  assign doneEvtSet     = operSet[OB_DONE];

  always_ff @(posedge clk) begin
    if (!rstN) regRdata <= '0;
    else if (regRd) begin
      case (regAddr)
        ADDR_OPER_COND: regRdata <= DATA_W'(operCond);
        ADDR_OPER_EVT:  regRdata <= DATA_W'(operEvt);
        ADDR_OPER_EN:   regRdata <= operEn;
        ADDR_QUES_COND: regRdata <= DATA_W'(quesCond);
        ADDR_QUES_EVT:  regRdata <= DATA_W'(quesEvt);
        ADDR_QUES_EN:   regRdata <= quesEn;
        default:        regRdata <= '0;
      endcase
    end else regRdata <= '0;
  end
endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
  import stat_irq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 17,
  parameter int HALF_MARK = 32768
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         regAddr,
  input  logic               regRd,
  input  logic               regWr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic               presetIn,
  input  logic               opcArm,
  input  logic               trigIn,
  input  logic               trigReady,
  input  logic               fifoWr,
  input  logic               fifoFull,
  input  logic [CNT_W-1:0]   fifoCount,
  input  logic               scanDone,
  input  logic               scpTrig,
  input  logic               measStart,
  input  logic               measDone,
  input  logic               algIrq,
  input  logic               overVolt,
  output logic               operSum,
  output logic               quesSum,
  output logic               irqReq,
  output logic [CAUSE_W-1:0] irqCause,
  output logic               opcPosted,
  output logic               inputOpen
);
  ctlStrobeT         strobe;
  logic              doneEvtPending, doneEvtSet;
  logic [OPER_W-1:0] operEvt;
  logic [QUES_W-1:0] quesEvt;
  logic [DATA_W-1:0] operEn, quesEn;
  logic              armed;

  assign armed = strobe.armed;

  stat_irq_ctl uCtl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRd(regRd), .regWr(regWr),
    .presetIn(presetIn), .opcArm(opcArm), .doneEvtPending(doneEvtPending),
    .doneEvtSet(doneEvtSet), .strobe(strobe), .opcPosted(opcPosted)
  );

  stat_irq_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W), .HALF_MARK(HALF_MARK)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .trigIn(trigIn), .trigReady(trigReady),
    .fifoWr(fifoWr), .fifoFull(fifoFull), .fifoCount(fifoCount), .scanDone(scanDone),
    .scpTrig(scpTrig), .measStart(measStart), .measDone(measDone), .algIrq(algIrq),
    .overVolt(overVolt), .operSum(operSum), .quesSum(quesSum), .irqReq(irqReq),
    .irqCause(irqCause), .inputOpen(inputOpen), .doneEvtPending(doneEvtPending),
    .doneEvtSet(doneEvtSet), .operEvt(operEvt), .quesEvt(quesEvt),
    .operEn(operEn), .quesEn(quesEn)
  );
endmodule

// File: rtl/stat_irq_chk.sv
module stat_irq_chk
  import stat_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              presetIn,
  input logic              opcArm,
  input logic              regRd,
  input logic [2:0]        regAddr,
  input logic              inputOpen,
  input logic              irqReq,
  input logic [OPER_W-1:0] operEvt,
  input logic [QUES_W-1:0] quesEvt,
  input logic [DATA_W-1:0] operEn,
  input logic [DATA_W-1:0] quesEn,
  input logic              armed
);
  // R1: latched operation events persist unless their register is read
  a_r1_oper_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(regRd && regAddr == ADDR_OPER_EVT) |=> ((operEvt & $past(operEvt)) == $past(operEvt)));

  // R1: latched questionable events persist unless their register is read
  a_r1_ques_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(regRd && regAddr == ADDR_QUES_EVT) |=> ((quesEvt & $past(quesEvt)) == $past(quesEvt)));

  // R2: with every enable and the arm off, no request can be raised
  a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (operEn == '0 && quesEn == '0 && !armed) |-> !irqReq);

  // R8: preset leaves both masks and the arm cleared
  a_r8_preset_clears: assert property (@(posedge clk) disable iff (!rstN)
    presetIn |=> (operEn == '0 && quesEn == '0 && !armed));

  // R9: reading a pending measurement-done event drops the arm
  a_r9_arm_drops: assert property (@(posedge clk) disable iff (!rstN)
    (armed && regRd && regAddr == ADDR_OPER_EVT && operEvt[OB_DONE] && !opcArm && !presetIn)
      |=> !armed);

  // R10: the input-open indication only falls through reset
  a_r10_volt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    inputOpen |=> inputOpen);
endmodule

bind stat_irq_ctrl stat_irq_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .presetIn(presetIn), .opcArm(opcArm), .regRd(regRd),
  .regAddr(regAddr), .inputOpen(inputOpen), .irqReq(irqReq), .operEvt(operEvt),
  .quesEvt(quesEvt), .operEn(operEn), .quesEn(quesEn), .armed(armed)
);

// File: tb/stat_irq_ctrl_test.sv
module stat_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regRd = 1'b0, regWr = 1'b0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic        presetIn = 1'b0, opcArm = 1'b0;
  logic        trigIn = 1'b0, trigReady = 1'b0, fifoWr = 1'b0, fifoFull = 1'b0;
  logic [16:0] fifoCount = '0;
  logic        scanDone = 1'b0, scpTrig = 1'b0, measStart = 1'b0, measDone = 1'b0;
  logic        algIrq = 1'b0, overVolt = 1'b0;
  logic        operSum, quesSum, irqReq, opcPosted, inputOpen;
  logic [8:0]  irqCause;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  stat_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRd(regRd), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .presetIn(presetIn), .opcArm(opcArm),
    .trigIn(trigIn), .trigReady(trigReady), .fifoWr(fifoWr), .fifoFull(fifoFull),
    .fifoCount(fifoCount), .scanDone(scanDone), .scpTrig(scpTrig),
    .measStart(measStart), .measDone(measDone), .algIrq(algIrq), .overVolt(overVolt),
    .operSum(operSum), .quesSum(quesSum), .irqReq(irqReq), .irqCause(irqCause),
    .opcPosted(opcPosted), .inputOpen(inputOpen)
  );

  // {operation mask[5:0], questionable mask[2:0], stimulus id[3:0], expected cause[8:0]}
  localparam int NVEC = 10;
  localparam logic [21:0] VEC [NVEC] = '{
    {6'h02, 3'h0, 4'd1, 9'h002},
    {6'h00, 3'h7, 4'd1, 9'h000},
    {6'h04, 3'h0, 4'd2, 9'h004},
    {6'h08, 3'h0, 4'd3, 9'h008},
    {6'h10, 3'h0, 4'd4, 9'h010},
    {6'h11, 3'h0, 4'd4, 9'h011},
    {6'h20, 3'h0, 4'd5, 9'h020},
    {6'h00, 3'h1, 4'd6, 9'h040},
    {6'h00, 3'h2, 4'd7, 9'h080},
    {6'h3F, 3'h0, 4'd6, 9'h000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic measCycle(output logic posted);
    @(negedge clk); measStart = 1'b1;
    @(negedge clk); measStart = 1'b0;
    @(negedge clk); measDone = 1'b1;
    @(negedge clk); posted = opcPosted; measDone = 1'b0;
  endtask

  task automatic doStim(input logic [3:0] id);
    logic p;
    case (id)
      4'd1: begin @(negedge clk); scanDone = 1'b1; @(negedge clk); scanDone = 1'b0; end
      4'd2: begin @(negedge clk); scpTrig = 1'b1; @(negedge clk); scpTrig = 1'b0; end
      4'd3: begin @(negedge clk); fifoCount = 17'd32768; @(negedge clk); fifoCount = '0; end
      4'd4: measCycle(p);
      4'd5: begin @(negedge clk); algIrq = 1'b1; @(negedge clk); algIrq = 1'b0; end
      4'd6: begin @(negedge clk); trigReady = 1'b0; trigIn = 1'b1; @(negedge clk); trigIn = 1'b0; end
      4'd7: begin @(negedge clk); fifoFull = 1'b1; fifoWr = 1'b1; @(negedge clk); fifoWr = 1'b0; fifoFull = 1'b0; end
      default: @(negedge clk);
    endcase
  endtask

  task automatic pulsePreset();
    @(negedge clk); presetIn = 1'b1; @(negedge clk); presetIn = 1'b0;
  endtask

  task automatic pulseArm();
    @(negedge clk); opcArm = 1'b1; @(negedge clk); opcArm = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R11 watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       posted;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 irqReq", irqReq, 0);
    check("R11 operSum", operSum, 0);
    check("R11 inputOpen", inputOpen, 0);
    rdReg(3'd2, d); check("R11 oper mask", d, 0);
    rdReg(3'd1, d); check("R11 oper event", d, 0);

    // table walk: R1 R2 R3
    for (int i = 0; i < NVEC; i++) begin
      logic [8:0] exp;
      exp = VEC[i][8:0];
      wrReg(3'd2, {2'b00, VEC[i][21:16]});
      wrReg(3'd6, {5'b0, VEC[i][15:13]});
      doStim(VEC[i][12:9]);
      settle();
      check($sformatf("R2 cause vec%0d", i), irqCause, exp);
      check($sformatf("R2 irqReq vec%0d", i), irqReq, exp != 0);
      check($sformatf("R2 operSum vec%0d", i), operSum, |exp[5:0]);
      check($sformatf("R2 quesSum vec%0d", i), quesSum, |exp[8:6]);
      rdReg(3'd1, d);
      rdReg(3'd5, d);
      @(negedge clk);
      check($sformatf("R3 cleared vec%0d", i), irqReq, 0);
    end
    wrReg(3'd2, 8'h00);
    wrReg(3'd6, 8'h00);

    // R3 unmapped address reads zero, mask reads back
    wrReg(3'd2, 8'h2A);
    rdReg(3'd2, d); check("R3 mask readback", d, 8'h2A);
    rdReg(3'd3, d); check("R3 unmapped", d, 0);
    wrReg(3'd2, 8'h00);

    // R3 set in the read cycle survives
    @(negedge clk); regRd = 1'b1; regAddr = 3'd1; scanDone = 1'b1;
    @(negedge clk); regRd = 1'b0; scanDone = 1'b0; d = regRdata;
    check("R3 read before set", d, 0);
    rdReg(3'd1, d); check("R3 set beats clear", d, 8'h02);
    rdReg(3'd1, d); check("R3 read clears", d, 0);

    // R4 trigger with ready is not early
    @(negedge clk); trigReady = 1'b1; trigIn = 1'b1;
    @(negedge clk); trigIn = 1'b0; trigReady = 1'b0;
    rdReg(3'd5, d); check("R4 ready trigger", d, 0);
    doStim(4'd6);
    rdReg(3'd5, d); check("R4 early trigger", d, 8'h01);

    // R5 write without full is not an overrun
    @(negedge clk); fifoWr = 1'b1;
    @(negedge clk); fifoWr = 1'b0;
    rdReg(3'd5, d); check("R5 write not full", d, 0);

    // R6 half-full mark
    @(negedge clk); fifoCount = 17'd32767;
    settle();
    rdReg(3'd1, d); check("R6 below mark", d, 0);
    @(negedge clk); fifoCount = 17'd32768;
    settle();
    rdReg(3'd1, d); check("R6 at mark", d, 8'h08);
    @(negedge clk); fifoCount = 17'd40000;
    settle();
    rdReg(3'd1, d); check("R6 no relatch", d, 0);
    rdReg(3'd0, d); check("R6 condition level", d, 8'h08);
    @(negedge clk); fifoCount = '0;
    @(negedge clk); fifoCount = 17'd32768;
    settle();
    rdReg(3'd1, d); check("R6 recross", d, 8'h08);
    @(negedge clk); fifoCount = '0;
    settle();
    rdReg(3'd1, d);

    // R7 measuring condition
    @(negedge clk); measStart = 1'b1;
    @(negedge clk); measStart = 1'b0;
    settle();
    rdReg(3'd0, d); check("R7 measuring set", d, 8'h01);
    @(negedge clk); measDone = 1'b1;
    @(negedge clk); measDone = 1'b0;
    settle();
    rdReg(3'd0, d); check("R7 measuring cleared", d, 0);
    rdReg(3'd1, d); check("R7 events", d, 8'h11);

    // R9 arm with bit 4 masked
    pulseArm();
    measCycle(posted);
    check("R9 opcPosted", posted, 1);
    settle();
    check("R9 armed irq", irqReq, 1);
    check("R9 armed cause", irqCause, 9'h010);
    check("R9 summary ignores arm", operSum, 0);
    rdReg(3'd1, d); check("R9 delivered event", d, 8'h11);
    @(negedge clk);
    check("R9 irq after read", irqReq, 0);
    measCycle(posted);
    settle();
    check("R9 arm gone", irqReq, 0);
    check("R9 no post unarmed", posted, 0);
    rdReg(3'd1, d);

    // R9 arm with bit 4 already enabled
    wrReg(3'd2, 8'h10);
    pulseArm();
    measCycle(posted);
    settle();
    rdReg(3'd1, d);
    measCycle(posted);
    settle();
    check("R9 mask kept", irqReq, 1);
    rdReg(3'd1, d);
    wrReg(3'd2, 8'h00);

    // R8 preset
    wrReg(3'd2, 8'h3F);
    wrReg(3'd6, 8'h07);
    doStim(4'd1);
    settle();
    check("R8 before preset", irqReq, 1);
    pulsePreset();
    @(negedge clk);
    check("R8 irq after preset", irqReq, 0);
    rdReg(3'd2, d); check("R8 oper mask", d, 0);
    rdReg(3'd6, d); check("R8 ques mask", d, 0);
    rdReg(3'd1, d); check("R8 event kept", d, 8'h02);
    pulseArm();
    pulsePreset();
    measCycle(posted);
    settle();
    check("R8 arm cleared", irqReq, 0);
    rdReg(3'd1, d);

    // R10 overvoltage
    wrReg(3'd6, 8'h04);
    @(negedge clk); overVolt = 1'b1;
    @(negedge clk); overVolt = 1'b0;
    settle();
    check("R10 inputOpen", inputOpen, 1);
    check("R10 cause", irqCause, 9'h100);
    rdReg(3'd5, d); check("R10 event", d, 8'h04);
    @(negedge clk);
    check("R10 irq cleared", irqReq, 0);
    rdReg(3'd4, d); check("R10 condition held", d, 8'h04);
    pulsePreset();
    @(negedge clk);
    check("R10 survives preset", inputOpen, 1);
    doReset();
    @(negedge clk);
    check("R10 reset clears", inputOpen, 0);
    rdReg(3'd4, d); check("R11 ques cond after reset", d, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule